// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a three-level translation tree held in memory. A requester presents the address with an access kind (read or write) and a privilege (kernel or user). The walker first classifies the address by its top two bits. It rejects addresses whose unused upper bits are malformed. It then issues up to three sequential 8-byte reads on a simple request/response memory port, one read per tree level. The response carries the translated physical address and the permission bits of the final entry, or a fault code that names the level where the walk stopped.

The virtual address is split into three equal index fields above a page offset. Each table holds exactly one page of 8-byte entries, so the page offset is three bits wider than an index field. The first table sits at the frame given by a base-frame input. Each later table sits at the frame stored in the previous entry. Kernel-segment addresses bypass the tree and map directly. Entries are only read and never written back. Only one walk is in flight at a time.

Top module: `pgw_walker`

## Requirements
- R1: With address bit 63 at 0, every bit from the top down to bit 3*LVL_W+LVL_W+3 must be 0. With bits 63 and 62 both at 1, every such bit must be 1. Any other pattern in those bits gives code 1 (address fault), level 0, physical address 0 and permission 0, and causes no memory read.
- R2: Bits 63:62 equal to 2'b10 select the kernel window. It causes no memory read and responds with code 0, level 0, permission 4'b1111 and a physical address equal to the low PA_W bits of the virtual address.
- R3: The level-L read (L = 0, 1, 2) goes to byte address {table_frame, index_L, 3'b000}. Index 0 is the most significant LVL_W-bit field just below the unused upper bits, and indices 1 and 2 follow it downward. The level-0 table frame is the base-frame input; each later table frame is the frame field of the entry read at the level before.
- R4: Entry layout: bit 0 valid, bit 1 kernel read, bit 2 kernel write, bit 3 user read, bit 4 user write, frame number at bits [32 +: PA_W-LVL_W-3]. All other entry bits are ignored.
- R5: An entry with the valid bit clear at level L ends the walk after exactly L+1 reads. The response has code 2 (page fault), level L, physical address 0 and permission 0.
- R6: At level 2 the enable bit for the requested privilege and access kind is checked. If it is clear, the response has code 3 (access violation), level 2, physical address 0 and permission 0. If it is set, the response has code 0, level 0, physical address {frame, page offset} and permission equal to entry bits 4:1.
- R7: A successful tree walk makes exactly three reads. While the read request is not accepted, the request stays asserted with a stable address.
- R8: The request-ready output is high only while the walker is idle. It stays low from the accepted request until the response has been accepted. The response stays valid and unchanged while response-ready is low.
- R9: After reset, request-ready is 1 and both the response-valid and memory-request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_frame | input | PA_W-LVL_W-3 | Frame number of the level-0 table |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | VA_W | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_user | input | 1 | 1 for user privilege, 0 for kernel |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned this cycle |
| mem_rsp_data | input | 64 | Returned 8-byte entry |
| rsp_valid | output | 1 | Walk result present |
| rsp_ready | input | 1 | Requester accepts the result |
| rsp_code | output | 2 | 0 ok, 1 address fault, 2 page fault, 3 access violation |
| rsp_level | output | 2 | Level at which a page fault or access violation occurred |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_perm | output | 4 | Final entry enables {user write, user read, kernel write, kernel read} |

## Verification
The bench builds the walker with LVL_W = 2 and PA_W = 16. Each table then has four entries, a page is 32 bytes and the meaningful address span is 11 bits. With so small a tree, all 64 index combinations can be swept under every privilege and access kind, in both user segments and from two base frames. A synthetic memory fills the entries arithmetically from their addresses. Invalid entries therefore appear at every level, and every enable bit is both granted and refused somewhere in the sweep. Further cases cover malformed upper bits just above the meaningful span and far above it, and the kernel window.

// File: rtl/pgw_pkg.sv
// Package: shared encodings for the page table walker.
// Assumes: two-bit fault and state encodings are enough for this block.
package pgw_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ADDR   = 2'd1,
        FLT_PAGE   = 2'd2,
        FLT_ACCESS = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        SEG_USER  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_KERN  = 2'd2
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

endpackage

// File: rtl/pgw_va_decode.sv
// Module: pgw_va_decode
// Classifies a virtual address by its top two bits, checks that the bits
// above the meaningful span are a clean extension for the user segments,
// and slices out the per-level table indices, most significant first.
// Assumes: SIG_W < VA_W - 2, so the segment bits lie in the unused span.
module pgw_va_decode
    import pgw_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int LVL_W  = 10,
    parameter int LEVELS = 3,
    parameter int SIG_W  = LEVELS * LVL_W + LVL_W + 3
) (
    input  logic [VA_W-1:0]              va,
    output seg_e                         seg,
    output logic                         ext_ok,
    output logic [LEVELS-1:0][LVL_W-1:0] idx
);

    localparam int UP_W = VA_W - SIG_W;

    logic [UP_W-1:0] upper;
    assign upper = va[VA_W-1:SIG_W];

    // Segment choice from the top two bits and the matching extension rule.
    always_comb begin
        if (!va[VA_W-1]) begin
            seg    = SEG_USER;
            ext_ok = (upper == '0);
        end else if (va[VA_W-2]) begin
            seg    = SEG_STACK;
            ext_ok = &upper;
        end else begin
            seg    = SEG_KERN;
            ext_ok = 1'b1;
        end
    end

    // One index slice per level, level 0 taken from the highest field.
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = va[SIG_W-1-g*LVL_W -: LVL_W];
    end

endmodule

// File: rtl/pgw_pte_check.sv
// Module: pgw_pte_check
// Splits an 8-byte entry into valid bit, frame number and the four enable
// bits, and selects the enable matching the requested privilege and kind.
// Assumes: frame field fits above bit PFN_LSB inside the entry.
module pgw_pte_check #(
    parameter int PTE_W   = 64,
    parameter int PFN_W   = 21,
    parameter int PFN_LSB = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    input  logic             is_user,
    output logic             valid,
    output logic [PFN_W-1:0] pfn,
    output logic [3:0]       perm,
    output logic             allowed
);

    logic rsvd_unused;

    // Field extraction; enables ordered kernel read, kernel write, user read, user write.
    always_comb begin
        valid       = pte[0];
        perm        = pte[4:1];
        pfn         = pte[PFN_LSB +: PFN_W];
        allowed     = perm[{is_user, is_write}];
        rsvd_unused = ^{pte[PFN_LSB-1:5], pte[PTE_W-1:PFN_LSB+PFN_W]};
    end

endmodule

// File: rtl/pgw_walker.sv
// Module: pgw_walker (top)
// Serial three-level translation walker. Accepts one request at a time,
// decodes the segment, either answers at once (kernel window or malformed
// upper bits) or reads one entry per level through a request/response
// port, then reports physical address and enables or a fault code.
// Assumes: each table fills exactly one page, so an entry address is the
// concatenation {table frame, index, 3'b000}; memory returns exactly one
// response per accepted request, never before acceptance.
module pgw_walker
    import pgw_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int LVL_W  = 10,
    parameter int LEVELS = 3,
    parameter int PA_W   = 34,
    localparam int OFF_W = LVL_W + 3,
    localparam int SIG_W = LEVELS * LVL_W + OFF_W,
    localparam int PFN_W = PA_W - OFF_W,
    localparam int LV_W  = (LEVELS > 2) ? $clog2(LEVELS) : 1,
    localparam int PTE_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PFN_W-1:0] base_frame,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic             req_user,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [1:0]       rsp_code,
    output logic [LV_W-1:0]  rsp_level,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [3:0]       rsp_perm
);

    localparam logic [LV_W-1:0] LAST_LVL = LV_W'(LEVELS - 1);

    walk_state_e                  state_q;
    logic [SIG_W-1:0]             va_q;
    logic                         wr_q;
    logic                         usr_q;
    logic [LV_W-1:0]              lvl_q;
    logic [PFN_W-1:0]             tbl_q;
    fault_e                       code_q;
    logic [LV_W-1:0]              flvl_q;
    logic [PA_W-1:0]              pa_q;
    logic [3:0]                   perm_q;

    logic [VA_W-1:0]              dec_va;
    seg_e                         dec_seg;
    logic                         dec_ext_ok;
    logic [LEVELS-1:0][LVL_W-1:0] dec_idx;

    logic                         pte_valid;
    logic [PFN_W-1:0]             pte_pfn;
    logic [3:0]                   pte_perm;
    logic                         pte_allowed;

    // Decode the live request while idle, the held address during a walk.
    assign dec_va = (state_q == ST_IDLE) ? req_va
                                         : {{(VA_W-SIG_W){1'b0}}, va_q};

    pgw_va_decode #(
        .VA_W   (VA_W),
        .LVL_W  (LVL_W),
        .LEVELS (LEVELS),
        .SIG_W  (SIG_W)
    ) u_decode (
        .va     (dec_va),
        .seg    (dec_seg),
        .ext_ok (dec_ext_ok),
        .idx    (dec_idx)
    );

    pgw_pte_check #(
        .PTE_W   (PTE_W),
        .PFN_W   (PFN_W),
        .PFN_LSB (32)
    ) u_pte (
        .pte      (mem_rsp_data),
        .is_write (wr_q),
        .is_user  (usr_q),
        .valid    (pte_valid),
        .pfn      (pte_pfn),
        .perm     (pte_perm),
        .allowed  (pte_allowed)
    );

    // Port outputs follow directly from the walk state and held results.
    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign mem_req_addr  = {tbl_q, dec_idx[lvl_q], 3'b000};
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_code      = code_q;
    assign rsp_level     = flvl_q;
    assign rsp_paddr     = pa_q;
    assign rsp_perm      = perm_q;

    // Walk sequencer: accept, read each level, judge the entry, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            lvl_q   <= '0;
            tbl_q   <= '0;
            code_q  <= FLT_NONE;
            flvl_q  <= '0;
            pa_q    <= '0;
            perm_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va[SIG_W-1:0];
                        wr_q   <= req_write;
                        usr_q  <= req_user;
                        lvl_q  <= '0;
                        tbl_q  <= base_frame;
                        flvl_q <= '0;
                        pa_q   <= '0;
                        perm_q <= '0;
                        if (dec_seg == SEG_KERN) begin
                            code_q  <= FLT_NONE;
                            pa_q    <= req_va[PA_W-1:0];
                            perm_q  <= 4'b1111;
                            state_q <= ST_RESP;
                        end else if (!dec_ext_ok) begin
                            code_q  <= FLT_ADDR;
                            state_q <= ST_RESP;
                        end else begin
                            code_q  <= FLT_NONE;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!pte_valid) begin
                            code_q  <= FLT_PAGE;
                            flvl_q  <= lvl_q;
                            state_q <= ST_RESP;
                        end else if (lvl_q != LAST_LVL) begin
                            tbl_q   <= pte_pfn;
                            lvl_q   <= lvl_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end else if (!pte_allowed) begin
                            code_q  <= FLT_ACCESS;
                            flvl_q  <= lvl_q;
                            state_q <= ST_RESP;
                        end else begin
                            code_q  <= FLT_NONE;
                            pa_q    <= {pte_pfn, va_q[OFF_W-1:0]};
                            perm_q  <= pte_perm;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R8

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) &&
            $stable(rsp_paddr) && $stable(rsp_level) && $stable(rsp_perm))); // R8

    AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (lvl_q <= LAST_LVL)); // R3

    AST_FAULT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != FLT_NONE) |-> (rsp_paddr == '0 && rsp_perm == '0)); // R5

    AST_KERN_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_va[VA_W-1:VA_W-2] == 2'b10) |=>
            (rsp_valid && rsp_code == FLT_NONE &&
             rsp_paddr == $past(req_va[PA_W-1:0]))); // R2

    AST_ADDR_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && dec_seg != SEG_KERN && !dec_ext_ok) |=>
            (rsp_valid && rsp_code == FLT_ADDR && !mem_req_valid)); // R1

endmodule

// File: tb/pgw_walker_tb.sv
// Bench: pgw_walker_tb_top
// Sweeps the walker in a small build (2-bit indices, 16-bit physical
// address) against a synthetic memory whose entries are computed from
// their addresses; expected results come from an arithmetic model.
module pgw_walker_tb_top;

    localparam int TB_LVL = 2;
    localparam int TB_PA  = 16;
    localparam int TB_OFF = TB_LVL + 3;
    localparam int TB_SIG = 3 * TB_LVL + TB_OFF;
    localparam int TB_PFN = TB_PA - TB_OFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TB_PFN-1:0] base_frame = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [63:0]       req_va = '0;
    logic              req_write = 1'b0;
    logic              req_user = 1'b0;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [TB_PA-1:0]  mem_req_addr;
    logic              mem_rsp_valid;
    logic [63:0]       mem_rsp_data;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [1:0]        rsp_code;
    logic [1:0]        rsp_level;
    logic [TB_PA-1:0]  rsp_paddr;
    logic [3:0]        rsp_perm;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int walks    = 0;

    // memory log
    int               rd_cnt = 0;
    logic [TB_PA-1:0] rd_addr [0:3];

    // expected values
    int               e_nrd;
    logic [1:0]       e_code;
    logic [1:0]       e_lvl;
    logic [TB_PA-1:0] e_pa;
    logic [3:0]       e_perm;
    logic [TB_PA-1:0] e_addr [0:2];

    always #4 clk = ~clk;

    pgw_walker #(
        .VA_W   (64),
        .LVL_W  (TB_LVL),
        .LEVELS (3),
        .PA_W   (TB_PA)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .base_frame    (base_frame),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_write     (req_write),
        .req_user      (req_user),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_code      (rsp_code),
        .rsp_level     (rsp_level),
        .rsp_paddr     (rsp_paddr),
        .rsp_perm      (rsp_perm)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h (walk %0d)", req, act, exp, walks);
        end
    endtask

    // Synthetic entry: contents derived from the entry's own address.
    function automatic logic [63:0] pte_at(input logic [TB_PA-1:0] a);
        logic [12:0] h;
        logic [63:0] e;
        h = a[TB_PA-1:3];
        e = '0;
        e[0] = (h % 13'd5) != 13'd3;
        e[4:1] = h[3:0] ^ h[7:4];
        e[32 +: TB_PFN] = TB_PFN'((32'(h) * 37 + 11));
        e[63:60] = 4'hA;
        e[20:8] = h;
        return e;
    endfunction

    // Arithmetic model of the walk from the requirements.
    task automatic compute_exp(input logic [63:0] va, input logic wr, input logic usr);
        logic [TB_PFN-1:0] tbl;
        logic [63:0]       e;
        logic [1:0]        ix;
        e_nrd = 0; e_code = 2'd0; e_lvl = 2'd0; e_pa = '0; e_perm = '0;
        e = '0;
        if (va[63:62] == 2'b10) begin
            e_pa = va[TB_PA-1:0];
            e_perm = 4'hF;
            return;
        end
        if ((!va[63] && va[63:TB_SIG] != '0) || (va[63] && !(&va[63:TB_SIG]))) begin
            e_code = 2'd1;
            return;
        end
        tbl = base_frame;
        for (int l = 0; l < 3; l++) begin
            ix = va[TB_SIG-1-2*l -: 2];
            e_addr[l] = {tbl, ix, 3'b000};
            e_nrd = l + 1;
            e = pte_at(e_addr[l]);
            if (!e[0]) begin
                e_code = 2'd2;
                e_lvl = 2'(l);
                return;
            end
            tbl = e[32 +: TB_PFN];
        end
        if (!e[1 + 2*int'(usr) + int'(wr)]) begin
            e_code = 2'd3;
            e_lvl = 2'd2;
            return;
        end
        e_pa = {tbl, va[TB_OFF-1:0]};
        e_perm = e[4:1];
    endtask

    // Memory model: stalls some requests, answers with 0..2 idle cycles.
    initial begin
        bit       busy;
        int       lat;
        int       stall;
        int       seq;
        logic [TB_PA-1:0] addr;
        busy = 0; lat = 0; stall = 0; seq = 0; addr = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (busy) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pte_at(addr);
                    busy = 0;
                end else begin
                    lat--;
                end
            end else if (rst_n && mem_req_valid) begin
                if (stall == 0) begin
                    mem_req_ready = 1'b1;
                    addr = mem_req_addr;
                    if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr;
                    rd_cnt++;
                    busy = 1;
                    lat = seq % 3;
                    stall = (seq + 1) % 2;
                    seq++;
                end else begin
                    stall--;
                end
            end
        end
    end

    task automatic do_walk(input logic [63:0] va, input logic wr, input logic usr, input int hold);
        int wait_cnt;
        walks++;
        compute_exp(va, wr, usr);
        @(negedge clk);
        rd_cnt = 0;
        check(req_ready == 1'b1, "R8 ready when idle", 64'(req_ready), 64'd1);
        req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_cnt = 0;
        while (!rsp_valid && wait_cnt < 200) begin
            check(req_ready == 1'b0, "R8 busy not ready", 64'(req_ready), 64'd0);
            @(negedge clk);
            wait_cnt++;
        end
        check(rsp_valid == 1'b1, "R8 response arrives", 64'(rsp_valid), 64'd1);
        if (e_code == 2'd1)
            check(rsp_code == e_code, "R1 address fault code", 64'(rsp_code), 64'(e_code));
        else if (va[63:62] == 2'b10)
            check(rsp_code == e_code, "R2 kernel code", 64'(rsp_code), 64'(e_code));
        else if (e_code == 2'd2)
            check(rsp_code == e_code, "R5 page fault code", 64'(rsp_code), 64'(e_code));
        else
            check(rsp_code == e_code, "R6 permission code", 64'(rsp_code), 64'(e_code));
        check(rsp_level == e_lvl, "R5 fault level", 64'(rsp_level), 64'(e_lvl));
        check(rsp_paddr == e_pa, "R6 physical address", 64'(rsp_paddr), 64'(e_pa));
        check(rsp_perm == e_perm, "R4 permission bits", 64'(rsp_perm), 64'(e_perm));
        check(rd_cnt == e_nrd, "R7 read count", 64'(rd_cnt), 64'(e_nrd));
        for (int k = 0; k < e_nrd && k < rd_cnt && k < 3; k++)
            check(rd_addr[k] == e_addr[k], "R3 entry address", 64'(rd_addr[k]), 64'(e_addr[k]));
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(rsp_valid == 1'b1 && rsp_code == e_code && rsp_paddr == e_pa,
                  "R8 response held", 64'(rsp_paddr), 64'(e_pa));
            check(req_ready == 1'b0, "R8 not ready while held", 64'(req_ready), 64'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R8 back to idle",
              64'({rsp_valid, req_ready}), 64'b01);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] va;
        base_frame = 11'h155;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(req_ready == 1'b1, "R9 reset ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check(mem_req_valid == 1'b0, "R9 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // Exhaustive sweep: base frames x index space x privilege/kind.
        for (int b = 0; b < 2; b++) begin
            base_frame = (b == 0) ? 11'h155 : 11'h02A;
            for (int i = 0; i < 64; i++) begin
                for (int m = 0; m < 4; m++) begin
                    va = {{(64-TB_SIG){i[0]}}, 6'(i), 5'((i * 7 + m) % 32)};
                    do_walk(va, m[0], m[1], (i + m) % 3);
                end
            end
        end

        // R1: malformed upper bits in both user segments.
        do_walk(64'h0000_0000_0000_0800, 1'b0, 1'b0, 1);
        do_walk(64'h0000_0100_0000_0123, 1'b1, 1'b1, 0);
        do_walk(64'h4000_0000_0000_0456, 1'b0, 1'b1, 2);
        do_walk(64'hFFFF_FFFF_FFFF_F7FF, 1'b0, 1'b0, 1);
        do_walk(64'hFFFF_FFFE_FFFF_FFFF, 1'b1, 1'b0, 0);

        // R2: kernel window, including junk in the middle bits.
        do_walk(64'h8000_0000_0000_ABCD, 1'b0, 1'b0, 1);
        do_walk(64'hBFFF_1234_5678_9A5E, 1'b1, 1'b1, 2);
        do_walk(64'h8000_0000_0000_0000, 1'b0, 1'b1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule